// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block is a memory-mapped port controller for a wide general-purpose I/O field (121 pins by default), with the pins spread over 32-bit banks. Each pin has a direction bit and an output latch. Software never writes the latch directly. It has two write-one strobe registers, one to raise the latch and one to lower it. Each pin also has a 2-bit function code. The code either keeps the pin under GPIO control or gives the pad to one of three external alternate sources.

The pad levels reach the register bus only after a two-flop synchronizer. The level register reports the true pad level whatever the pin direction, so software can read back a pin it is driving. The latch follows set and clear writes even while the pin is an input. The stored value reaches the pad when the direction bit is later switched to output. The register read port is combinational on the address. Writes take effect on the clock edge where the write enable is high.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin p maps to bit p mod 32 of bank p div 32. Bank 3 carries pins 96 to 120 in bits 0 to 24.
- R2: After reset every direction bit, every latch bit and every function code is zero, and pad_oe is all zero.
- R3: Writing 1 to a bit of a set register drives that pin's latch to 1. Writing 1 to a bit of a clear register drives it to 0. Bits written as 0 leave the latch unchanged.
- R4: A set or clear write updates the latch while the pin is an input (pad_oe low). The stored value appears on pad_out once the direction bit becomes 1.
- R5: When set and clear writes hit the same bit one after the other, the later write determines the latch value.
- R6: The level register returns the pad_in value that has been stable for at least two clock edges, for inputs and outputs alike. A pad change becomes visible on the bus after exactly two rising edges.
- R7: The byte offsets for banks 0, 1 and 2 are: level 0x00/0x04/0x08, direction 0x0C/0x10/0x14, set 0x18/0x1C/0x20, clear 0x24/0x28/0x2C. Bank 3 of each register sits at the bank-0 offset plus 0x100.
- R8: Function codes are held in eight words at 0x30 + 4k. Pin p's code sits in word p div 16, bits 2(p mod 16)+1 down to 2(p mod 16). Code 0 selects GPIO. Codes 1, 2 and 3 drive pad_out and pad_oe of pin p from alt_out and alt_oe bit (code-1)*121+p.
- R9: Reads of set and clear registers and of unmapped offsets return 0. Bits beyond pin 120 read 0 and ignore writes.
- R10: With code 0, pad_oe equals the pin's direction bit (1 = output) and pad_out equals its latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 121 | Raw pad input levels |
| alt_out | input | 363 | Alternate-source output values, source-major |
| alt_oe | input | 363 | Alternate-source output enables, source-major |
| pad_out | output | 121 | Pad output values |
| pad_oe | output | 121 | Pad output enables |
| pin_level | output | 121 | Synchronized pad levels |

## Verification
The hardest case to reach is a pin whose latch was changed while it was an input and that is only then turned into an output. A purely random register stream seldom sets up that ordering on one pin. Directed steps therefore arm the latch of an input pin and flip its direction afterwards, and do the same for back-to-back set and clear on one bit. A second hard case is the level read of a driven pin whose pad disagrees with the latch. The stimulus forces pad_in against the latch of an output pin and reads the level once the synchronizer has settled. Random bank writes mixed with pad changes cover the remaining state space.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      KIND_LEVEL = 2'd0,
      KIND_DIR   = 2'd1,
      KIND_SET   = 2'd2,
      KIND_CLR   = 2'd3
   } reg_kind_e;

   // byte offset of one bank of one register kind; the last bank lives in a high window
   function automatic int unsigned bank_offset(input int unsigned kind,
                                               input int unsigned bank,
                                               input int unsigned num_banks,
                                               input int unsigned high_base);
      int unsigned stride;
      stride = 4 * (num_banks - 1);
      if (bank == num_banks - 1)
         return high_base + kind * stride;
      return kind * stride + bank * 4;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 121,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= din;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign dout = stg_q[STAGES-1];

   generate
      if (STAGES == 2) begin : g_lat_chk
         logic [1:0] since_rst;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) since_rst <= '0;
            else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
         end
         AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3) |-> (dout == $past(din, 2)))
            else $error("sync latency"); // R6
      end
   endgenerate
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs #(
   parameter int unsigned NUM_PINS = 121
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   dir_wr,
   input  logic [NUM_PINS-1:0]   dir_val,
   input  logic [NUM_PINS-1:0]   set_p,
   input  logic [NUM_PINS-1:0]   clr_p,
   input  logic [NUM_PINS-1:0]   af_wr,
   input  logic [2*NUM_PINS-1:0] af_val,
   output logic [NUM_PINS-1:0]   dir_q,
   output logic [NUM_PINS-1:0]   lat_q,
   output logic [2*NUM_PINS-1:0] af_q
);
   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dir_q[p]       <= 1'b0;
               lat_q[p]       <= 1'b0;
               af_q[2*p +: 2] <= 2'b00;
            end else begin
               if (dir_wr[p]) dir_q[p] <= dir_val[p];
               if (set_p[p])      lat_q[p] <= 1'b1;
               else if (clr_p[p]) lat_q[p] <= 1'b0;
               if (af_wr[p]) af_q[2*p +: 2] <= af_val[2*p +: 2];
            end
         end

         AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            set_p[p] |=> lat_q[p]) else $error("set strobe"); // R3
         AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_p[p] && !set_p[p]) |=> !lat_q[p]) else $error("clr strobe"); // R3
         AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_p[p] && !clr_p[p]) |=> $stable(lat_q[p])) else $error("latch hold"); // R4
      end
   endgenerate
endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux #(
   parameter int unsigned NUM_PINS = 121,
   parameter int unsigned NUM_ALT  = 3
) (
   input  logic [NUM_PINS-1:0]         lat_q,
   input  logic [NUM_PINS-1:0]         dir_q,
   input  logic [2*NUM_PINS-1:0]       af_q,
   input  logic [NUM_ALT*NUM_PINS-1:0] alt_out,
   input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe,
   output logic [NUM_PINS-1:0]         pad_out,
   output logic [NUM_PINS-1:0]         pad_oe
);
   generate
      if (NUM_ALT != 3) begin : g_bad_alt
         $error("two-bit codes select exactly three alternate sources");
      end
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         always_comb begin
            unique case (af_q[2*p +: 2])
               2'd1:    begin pad_out[p] = alt_out[p];              pad_oe[p] = alt_oe[p]; end
               2'd2:    begin pad_out[p] = alt_out[NUM_PINS + p];   pad_oe[p] = alt_oe[NUM_PINS + p]; end
               2'd3:    begin pad_out[p] = alt_out[2*NUM_PINS + p]; pad_oe[p] = alt_oe[2*NUM_PINS + p]; end
               default: begin pad_out[p] = lat_q[p];                pad_oe[p] = dir_q[p]; end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 121,
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HIGH_BASE   = 256,
   parameter int unsigned NUM_ALT     = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_we,
   input  logic [31:0]                  bus_wdata,
   output logic [31:0]                  bus_rdata,
   input  logic [NUM_PINS-1:0]          pad_in,
   input  logic [NUM_ALT*NUM_PINS-1:0]  alt_out,
   input  logic [NUM_ALT*NUM_PINS-1:0]  alt_oe,
   output logic [NUM_PINS-1:0]          pad_out,
   output logic [NUM_PINS-1:0]          pad_oe,
   output logic [NUM_PINS-1:0]          pin_level
);
   localparam int unsigned NUM_BANKS  = (NUM_PINS + WORD_W - 1) / WORD_W;
   localparam int unsigned PADDED     = NUM_BANKS * WORD_W;
   localparam int unsigned AF_PER_WD  = WORD_W / 2;
   localparam int unsigned AF_WORDS   = (NUM_PINS + AF_PER_WD - 1) / AF_PER_WD;
   localparam int unsigned AF_PADDED  = AF_WORDS * WORD_W;
   localparam int unsigned AF_BASE    = 4 * 4 * (NUM_BANKS - 1);

   generate
      if (NUM_BANKS < 2) begin : g_bad_banks
         $error("at least two banks are required");
      end
      if (AF_BASE + 4 * AF_WORDS > HIGH_BASE) begin : g_bad_map
         $error("function-code words overlap the high bank window");
      end
      if ((HIGH_BASE + 4 * 4 * (NUM_BANKS - 1)) > (1 << ADDR_W)) begin : g_bad_addr
         $error("address width too small for the register map");
      end
   endgenerate

   logic [NUM_PINS-1:0]   dir_q, lat_q;
   logic [2*NUM_PINS-1:0] af_q;
   logic [NUM_BANKS-1:0]  hit_dir, hit_set, hit_clr;
   logic [AF_WORDS-1:0]   hit_af;
   logic [NUM_PINS-1:0]   dir_wr, dir_val, set_p, clr_p, af_wr;
   logic [2*NUM_PINS-1:0] af_val;

   // ---- write decode -------------------------------------------------
   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         hit_dir[b] = bus_we && (bus_addr == ADDR_W'(bank_offset(KIND_DIR, b, NUM_BANKS, HIGH_BASE)));
         hit_set[b] = bus_we && (bus_addr == ADDR_W'(bank_offset(KIND_SET, b, NUM_BANKS, HIGH_BASE)));
         hit_clr[b] = bus_we && (bus_addr == ADDR_W'(bank_offset(KIND_CLR, b, NUM_BANKS, HIGH_BASE)));
      end
      for (int k = 0; k < AF_WORDS; k++)
         hit_af[k] = bus_we && (bus_addr == ADDR_W'(AF_BASE + 4 * k));
      for (int p = 0; p < NUM_PINS; p++) begin
         dir_wr[p]        = hit_dir[p / WORD_W];
         dir_val[p]       = bus_wdata[p % WORD_W];
         set_p[p]         = hit_set[p / WORD_W] && bus_wdata[p % WORD_W];
         clr_p[p]         = hit_clr[p / WORD_W] && bus_wdata[p % WORD_W];
         af_wr[p]         = hit_af[p / AF_PER_WD];
         af_val[2*p +: 2] = bus_wdata[2 * (p % AF_PER_WD) +: 2];
      end
   end

   gpio_pin_regs #(.NUM_PINS(NUM_PINS)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .dir_wr(dir_wr), .dir_val(dir_val), .set_p(set_p), .clr_p(clr_p),
      .af_wr(af_wr), .af_val(af_val),
      .dir_q(dir_q), .lat_q(lat_q), .af_q(af_q)
   );

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_level)
   );

   gpio_out_mux #(.NUM_PINS(NUM_PINS), .NUM_ALT(NUM_ALT)) mux_i (
      .lat_q(lat_q), .dir_q(dir_q), .af_q(af_q),
      .alt_out(alt_out), .alt_oe(alt_oe),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // ---- read mux (set/clear and unmapped read as zero) -----------------
   logic [PADDED-1:0]    lvl_pad, dir_pad;
   logic [AF_PADDED-1:0] af_pad;
   assign lvl_pad = PADDED'(pin_level);
   assign dir_pad = PADDED'(dir_q);
   assign af_pad  = AF_PADDED'(af_q);

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == ADDR_W'(bank_offset(KIND_LEVEL, b, NUM_BANKS, HIGH_BASE)))
            bus_rdata = lvl_pad[b*WORD_W +: WORD_W];
         if (bus_addr == ADDR_W'(bank_offset(KIND_DIR, b, NUM_BANKS, HIGH_BASE)))
            bus_rdata = dir_pad[b*WORD_W +: WORD_W];
      end
      for (int k = 0; k < AF_WORDS; k++)
         if (bus_addr == ADDR_W'(AF_BASE + 4 * k))
            bus_rdata = af_pad[k*WORD_W +: WORD_W];
   end

   AST_RESET_ALL_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0)) else $error("pads driven after reset"); // R2
   AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(bank_offset(KIND_SET, 0, NUM_BANKS, HIGH_BASE))) |-> (bus_rdata == '0))
      else $error("set register readable"); // R9
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({|set_p, |clr_p}) <= 1) else $error("set and clear together"); // R5
endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
   localparam int N   = 121;
   localparam int NB  = 4;
   localparam int AFW = 8;
   localparam int AFB = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [8:0]     bus_addr = '0;
   logic           bus_we = 1'b0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [N-1:0]   pad_in = '0;
   logic [3*N-1:0] alt_out = '0, alt_oe = '0;
   logic [N-1:0]   pad_out, pad_oe, pin_level;

   int checks = 0, errors = 0;
   logic [N-1:0]   m_dir = '0, m_lat = '0;
   logic [2*N-1:0] m_af = '0;

   always #4 clk = ~clk;

   gpio_bank_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe),
      .pin_level(pin_level)
   );

   function automatic int unsigned off(int kind, int bank);
      if (bank == NB - 1) return 256 + kind * 12;
      return kind * 12 + bank * 4;
   endfunction

   function automatic logic [31:0] exp_rd(int unsigned a);
      logic [31:0] r = '0;
      for (int b = 0; b < NB; b++) begin
         for (int i = 0; i < 32; i++) begin
            if (b*32 + i < N) begin
               if (a == off(0, b)) r[i] = pad_in[b*32+i];
               if (a == off(1, b)) r[i] = m_dir[b*32+i];
            end
         end
      end
      for (int k = 0; k < AFW; k++)
         for (int j = 0; j < 16; j++)
            if (a == AFB + 4*k && k*16 + j < N) r[2*j +: 2] = m_af[2*(k*16+j) +: 2];
      return r;
   endfunction

   function automatic logic [N-1:0] rand_pins();
      logic [N-1:0] v;
      for (int p = 0; p < N; p++) v[p] = 1'($urandom_range(0, 1));
      return v;
   endfunction

   task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic checkn(string req, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_pads(string req);
      logic [N-1:0] eo, ee;
      #1;
      for (int p = 0; p < N; p++) begin
         int c = int'(m_af[2*p +: 2]);
         if (c == 0) begin eo[p] = m_lat[p]; ee[p] = m_dir[p]; end
         else begin eo[p] = alt_out[(c-1)*N + p]; ee[p] = alt_oe[(c-1)*N + p]; end
      end
      checkn({req, " pad_out"}, pad_out, eo);
      checkn({req, " pad_oe"}, pad_oe, ee);
   endtask

   task automatic wr(int unsigned a, logic [31:0] d);
      @(negedge clk);
      bus_addr = 9'(a); bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      for (int b = 0; b < NB; b++)
         for (int i = 0; i < 32; i++)
            if (b*32 + i < N) begin
               if (a == off(1, b)) m_dir[b*32+i] = d[i];
               if (a == off(2, b) && d[i]) m_lat[b*32+i] = 1'b1;
               if (a == off(3, b) && d[i]) m_lat[b*32+i] = 1'b0;
            end
      for (int k = 0; k < AFW; k++)
         for (int j = 0; j < 16; j++)
            if (a == AFB + 4*k && k*16 + j < N) m_af[2*(k*16+j) +: 2] = d[2*j +: 2];
   endtask

   task automatic rd_chk(int unsigned a, string req);
      @(negedge clk);
      bus_addr = 9'(a);
      #1;
      check32(req, bus_rdata, exp_rd(a));
   endtask

   task automatic set_pads(logic [N-1:0] v);
      @(negedge clk);
      pad_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      alt_out = {rand_pins(), rand_pins(), rand_pins()};
      alt_oe  = {rand_pins(), rand_pins(), rand_pins()};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      check_pads("R2 reset");
      checkn("R2 pad_oe zero", pad_oe, '0);
      for (int b = 0; b < NB; b++) rd_chk(off(1, b), "R2 dir reset");
      for (int k = 0; k < AFW; k++) rd_chk(AFB + 4*k, "R2 af reset");

      // R4: latch written while input, appears when made output
      wr(off(2, 0), 32'h20);
      check_pads("R4 input hides latch");
      checkn("R4 pad_oe still low", pad_oe & (N'(1) << 5), '0);
      wr(off(1, 0), 32'h20);
      check_pads("R4 latch shows after dir");
      checkn("R10 pin5 driven high", {pad_oe[5], pad_out[5]} , N'(2'b11));

      // R5: later write wins, both orders; R3 zeros no effect
      wr(off(1, 1), 32'h0000_0100);
      wr(off(2, 1), 32'h0000_0100);
      wr(off(3, 1), 32'h0000_0100);
      check_pads("R5 set then clear");
      wr(off(3, 1), 32'h0000_0100);
      wr(off(2, 1), 32'h0000_0100);
      check_pads("R5 clear then set");
      wr(off(2, 1), 32'h0);
      wr(off(3, 1), 32'h0);
      check_pads("R3 zero writes no effect");

      // R1/R9: bank 3 reserved bits ignore writes and read zero
      wr(off(1, 3), 32'hFFFF_FFFF);
      rd_chk(off(1, 3), "R1 R9 bank3 dir");
      check32("R9 bank3 mask", exp_rd(off(1, 3)), 32'h01FF_FFFF);
      wr(off(2, 3), 32'hFFFF_FFFF);
      check_pads("R1 bank3 set");
      rd_chk(off(2, 3), "R9 set reads zero");
      rd_chk(off(3, 0), "R9 clear reads zero");
      rd_chk(9'h080, "R9 unmapped zero");

      // R6: level of a driven pin shows the pad, not the latch
      set_pads(~m_lat);
      rd_chk(off(0, 0), "R6 level bank0");
      rd_chk(off(0, 3), "R6 level bank3");
      checkn("R6 pin_level", pin_level, pad_in);

      // R8: alternate-function codes
      wr(AFB, 32'h0000_E4C0); // pin3=3, pin4=0... pins 5..7 codes
      check_pads("R8 af select");
      rd_chk(AFB, "R8 af readback");
      wr(AFB + 28, 32'hFFFF_FFFF);
      rd_chk(AFB + 28, "R8 R9 af last word");
      check_pads("R8 af high pins");

      // R7 and the rest: random traffic
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 5);
         int b  = $urandom_range(0, NB - 1);
         logic [31:0] d = $urandom;
         case (op)
            0: wr(off(1, b), d);
            1: wr(off(2, b), d);
            2: wr(off(3, b), d);
            3: wr(AFB + 4 * $urandom_range(0, AFW - 1), d & 32'h5555_5555 & $urandom);
            4: set_pads(rand_pins());
            default: begin
               alt_out = {rand_pins(), rand_pins(), rand_pins()};
               alt_oe  = {rand_pins(), rand_pins(), rand_pins()};
            end
         endcase
         check_pads("R3 R8 R10 random");
         rd_chk(off($urandom_range(0, 3), b), "R7 random read");
      end

      finish_run();
   end
endmodule